// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block gives a host I/O bus the classic two-port route into device configuration space. An eight-port window, by default at I/O ports 0xCF8 to 0xCFF, is split in two halves. The lower four ports hold a 32-bit address latch. The upper four ports form a data window. A data access uses the fields held in the latch (bus, device, function, dword register number) to reach one device's configuration storage.

Host accesses come as single-cycle read or write strobes with a port address, a size code and lane-aligned data. An access to the data window that targets bus 0 and a device marked present is passed as a combinational request to a configuration back end. The back end returns read data in the same cycle. A read always completes one cycle after its strobe. Reads to a nonzero bus or to an absent device return all ones. Writes to those targets are dropped. A write to an absent device on bus 0 also raises a sticky flag, which the host can clear.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset the address latch reads back as zero, and io_rvalid, io_err and absent_wr_err are all low.
- R2: The latch keeps all 32 written bits. Its fields are: register dword number in bits 7:2, function in bits 10:8, device in bits 15:11, bus in bits 23:16, and the enable flag in bit 31. A dword written at the lowest port reads back unchanged.
- R3: The size code io_size is 0 for one byte, 1 for two bytes, 2 for four bytes, and 3 is never legal. The offset is the low two port bits. Legal combinations are:
  - a byte access at any offset;
  - a two-byte access at offsets 0 to 2;
  - a four-byte access at offset 0 only.
  Any other access to either half pulses io_err for one cycle, one cycle after the strobe. Such an access changes nothing, issues no back-end request, and a read of this kind returns zero data.
- R4: A byte or two-byte write to the latch changes only the addressed byte lanes. All other lanes keep their value.
- R5: Every read strobe inside the window produces io_rvalid for exactly one cycle, one cycle after the strobe. Data for the access offset..offset+n-1 sits in those byte lanes, where lane k is bits 8k+7:8k. All other lanes read as zero.
- R6: A legal data-window access whose latched bus is 0 and whose device bit in dev_present is set raises cfg_req in the strobe cycle. The request carries:
  - cfg_we for writes;
  - the latched device on cfg_dev;
  - the lane-aligned write data.
  A read returns cfg_rdata restricted to the accessed lanes.
- R7: The request carries the latched register dword number on cfg_reg and the accessed lanes on cfg_be. The byte index touched in each enabled lane k is 4*cfg_reg + k, so successive bytes of a multi-byte access use consecutive indices.
- R8: A data-window read with a nonzero latched bus returns 0xFF in every accessed lane and issues no request.
- R9: A data-window read on bus 0 to a device whose dev_present bit is clear returns 0xFF in every accessed lane and issues no request.
- R10: A data-window write with a nonzero latched bus is dropped. It issues no request and leaves absent_wr_err unchanged.
- R11: A data-window write on bus 0 to an absent device is dropped and sets absent_wr_err one cycle later. The flag stays set until err_clr is high at a clock edge with no new such write in that cycle.
- R12: Strobes at ports outside the eight-port window are ignored. They produce no io_rvalid, no io_err, no request and no change to the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 16 | Host I/O port address |
| io_size | input | 2 | Access size code (0 byte, 1 word, 2 dword) |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_wdata | input | 32 | Write data, lane aligned |
| io_rdata | output | 32 | Read data, lane aligned, valid with io_rvalid |
| io_rvalid | output | 1 | Read completion pulse |
| io_err | output | 1 | Illegal size/offset pulse |
| dev_present | input | 32 | One bit per device number on bus 0 |
| cfg_req | output | 1 | Back-end request, same cycle as strobe |
| cfg_we | output | 1 | Back-end request is a write |
| cfg_dev | output | 5 | Target device number |
| cfg_reg | output | 6 | Target register dword number |
| cfg_be | output | 4 | Byte lanes of the request |
| cfg_wdata | output | 32 | Write data to the back end |
| cfg_rdata | input | 32 | Read data from the back end, same cycle |
| absent_wr_err | output | 1 | Sticky flag: write to absent device |
| err_clr | input | 1 | Clears absent_wr_err |

## Verification
Several properties are checked on every cycle by the assertions:
- a read strobe in the window is always followed by a completion;
- an illegal access never reaches the back end;
- a request only ever targets bus 0 and a present device;
- the latch holds still unless a legal write addresses it;
- the sticky flag never drops without a clear.

Other behaviour can only be shown by the bench scenarios, because the right answer depends on what was written earlier:
- the exact lane placement of read data;
- the all-ones fill for missing targets;
- partial-lane merging in the latch;
- the register number and byte enables seen by the back end.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    // Latched configuration address, most significant field first.
    typedef struct packed {
        logic       en;
        logic [6:0] rsv_hi;
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] reg_no;
        logic [1:0] rsv_lo;
    } cfg_addr_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_BAD   = 2'd3
    } io_size_e;

    // Size/offset legality inside a 4-byte port group.
    function automatic logic size_ok(io_size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE:  return 1'b1;
            SZ_WORD:  return (off != 2'd3);
            SZ_DWORD: return (off == 2'd0);
            default:  return 1'b0;
        endcase
    endfunction

    function automatic logic [3:0] lane_mask(io_size_e sz, logic [1:0] off);
        case (sz)
            SZ_BYTE:  return 4'b0001 << off;
            SZ_WORD:  return 4'b0011 << off;
            SZ_DWORD: return 4'b1111;
            default:  return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] expand_lanes(logic [3:0] m);
        logic [31:0] r;
        for (int k = 0; k < 4; k++) begin
            r[8*k +: 8] = {8{m[k]}};
        end
        return r;
    endfunction

endpackage

// File: rtl/cfg_access_check.sv
module cfg_access_check
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h0CF8
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    output logic              hit,
    output logic              sel_data,
    output logic              legal,
    output logic [3:0]        lanes
);
    localparam int HI = ADDR_W - 1;

    logic [1:0] off;
    io_size_e   sz;

    always_comb begin
        off      = io_addr[1:0];
        sz       = io_size_e'(io_size);
        hit      = (io_addr[HI:3] == BASE[HI:3]);
        sel_data = io_addr[2];
        legal    = size_ok(sz, off);
        lanes    = legal ? lane_mask(sz, off) : 4'b0000;
    end
endmodule

// File: rtl/cfg_addr_latch.sv
module cfg_addr_latch
    import cfgp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  lanes,
    input  logic [31:0] wdata,
    output cfg_addr_t   addr_q
);
    typedef struct packed {
        cfg_addr_t addr;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < 4; b++) begin
                if (lanes[b]) begin
                    st_d.addr[8*b +: 8] = wdata[8*b +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_q = st_q.addr;

    // R3 R12
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.addr));
endmodule

// File: rtl/cfg_window.sv
module cfg_window
    import cfgp_pkg::*;
#(
    parameter int NDEV = 32,
    localparam int DEV_W = $clog2(NDEV)
) (
    input  cfg_addr_t   addr_q,
    input  logic [NDEV-1:0] dev_present,
    input  logic        go,
    input  logic        is_wr,
    input  logic [3:0]  lanes,
    input  logic [31:0] wdata,
    output logic        cfg_req,
    output logic        cfg_we,
    output logic [DEV_W-1:0] cfg_dev,
    output logic [5:0]  cfg_reg,
    output logic [3:0]  cfg_be,
    output logic [31:0] cfg_wdata,
    output logic        float_rd,
    output logic        absent_wr
);
    logic bus_zero;
    logic dev_here;

    always_comb begin
        bus_zero  = (addr_q.bus == 8'd0);
        dev_here  = dev_present[addr_q.dev[DEV_W-1:0]];
        cfg_req   = go && bus_zero && dev_here;
        cfg_we    = cfg_req && is_wr;
        cfg_dev   = addr_q.dev[DEV_W-1:0];
        cfg_reg   = addr_q.reg_no;
        cfg_be    = cfg_req ? lanes : 4'b0000;
        cfg_wdata = wdata & expand_lanes(lanes);
        float_rd  = go && !is_wr && !(bus_zero && dev_here);
        absent_wr = go && is_wr && bus_zero && !dev_here;
    end
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W = 16,
    parameter logic [15:0] BASE   = 16'h0CF8,
    parameter int          NDEV   = 32,
    localparam int DEV_W = $clog2(NDEV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [1:0]        io_size,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              io_rvalid,
    output logic              io_err,
    input  logic [NDEV-1:0]   dev_present,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [DEV_W-1:0]  cfg_dev,
    output logic [5:0]        cfg_reg,
    output logic [3:0]        cfg_be,
    output logic [31:0]       cfg_wdata,
    input  logic [31:0]       cfg_rdata,
    output logic              absent_wr_err,
    input  logic              err_clr
);
    typedef struct packed {
        logic        rvalid;
        logic [31:0] rdata;
        logic        err;
        logic        sticky;
    } top_st_t;

    top_st_t   st_d, st_q;
    cfg_addr_t addr_q;

    logic       hit, sel_data, legal;
    logic [3:0] lanes;
    logic       any_go, rd_go, wr_go, latch_wr, win_go;
    logic       float_rd, absent_wr;
    logic [31:0] lane_bits;

    cfg_access_check #(.ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
        .io_addr  (io_addr),
        .io_size  (io_size),
        .hit      (hit),
        .sel_data (sel_data),
        .legal    (legal),
        .lanes    (lanes)
    );

    always_comb begin
        any_go    = hit && (io_rd || io_wr);
        wr_go     = hit && io_wr;
        rd_go     = hit && io_rd && !io_wr;
        latch_wr  = wr_go && !sel_data && legal;
        win_go    = any_go && sel_data && legal;
        lane_bits = expand_lanes(lanes);
    end

    cfg_addr_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (latch_wr),
        .lanes  (lanes),
        .wdata  (io_wdata),
        .addr_q (addr_q)
    );

    cfg_window #(.NDEV(NDEV)) u_win (
        .addr_q      (addr_q),
        .dev_present (dev_present),
        .go          (win_go),
        .is_wr       (io_wr),
        .lanes       (lanes),
        .wdata       (io_wdata),
        .cfg_req     (cfg_req),
        .cfg_we      (cfg_we),
        .cfg_dev     (cfg_dev),
        .cfg_reg     (cfg_reg),
        .cfg_be      (cfg_be),
        .cfg_wdata   (cfg_wdata),
        .float_rd    (float_rd),
        .absent_wr   (absent_wr)
    );

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd_go;
        st_d.err    = any_go && !legal;
        st_d.rdata  = '0;
        if (rd_go && legal) begin
            if (!sel_data) begin
                st_d.rdata = addr_q & lane_bits;
            end else if (float_rd) begin
                st_d.rdata = lane_bits;
            end else begin
                st_d.rdata = cfg_rdata & lane_bits;
            end
        end
        if (absent_wr) begin
            st_d.sticky = 1'b1;
        end else if (err_clr) begin
            st_d.sticky = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_rvalid     = st_q.rvalid;
    assign io_rdata      = st_q.rdata;
    assign io_err        = st_q.err;
    assign absent_wr_err = st_q.sticky;

    // R5
    rd_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && io_rd && !io_wr) |=> io_rvalid);

    // R3
    illegal_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !legal |-> !cfg_req);

    // R6 R8 R9 R10
    req_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_req |-> (addr_q.bus == 8'd0 && dev_present[addr_q.dev[DEV_W-1:0]]));

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (absent_wr_err && !err_clr) |=> absent_wr_err);

    // R12
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> (!io_rvalid && !io_err));
endmodule

// File: tb/cfg_port_bridge_test.sv
module cfg_port_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [1:0]  io_size = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        io_rvalid, io_err;
    logic [31:0] dev_present = 32'h0000_0009;
    logic        cfg_req, cfg_we;
    logic [4:0]  cfg_dev;
    logic [5:0]  cfg_reg;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        absent_wr_err;
    logic        err_clr = 1'b0;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // Back-end model: read data built from the request fields.
    assign cfg_rdata = {3'b101, cfg_dev, 2'b00, cfg_reg, 16'h5AC3};

    cfg_port_bridge uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_size(io_size),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_rvalid(io_rvalid), .io_err(io_err), .dev_present(dev_present),
        .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dev(cfg_dev), .cfg_reg(cfg_reg),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .absent_wr_err(absent_wr_err), .err_clr(err_clr)
    );

    // Captured values of the last access
    logic        c_req, c_we;
    logic [4:0]  c_dev;
    logic [5:0]  c_reg;
    logic [3:0]  c_be;
    logic [31:0] c_wdata;
    logic        r_valid, r_err, r_after;
    logic [31:0] r_data;

    function automatic logic [31:0] mk(logic en, logic [7:0] bus, logic [4:0] dev,
                                       logic [2:0] fn, logic [5:0] rg);
        return {en, 7'd0, bus, dev, fn, rg, 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    // One access: drive at negedge, capture request, sample result next negedge.
    task automatic acc(input logic [15:0] a, input logic [1:0] sz, input bit wr,
                       input logic [31:0] wd);
        @(negedge clk);
        io_addr = a; io_size = sz; io_wr = wr; io_rd = !wr; io_wdata = wd;
        #1;
        c_req = cfg_req; c_we = cfg_we; c_dev = cfg_dev; c_reg = cfg_reg;
        c_be = cfg_be; c_wdata = cfg_wdata;
        @(negedge clk);
        r_valid = io_rvalid; r_err = io_err; r_data = io_rdata;
        io_rd = 0; io_wr = 0;
        @(negedge clk);
        r_after = io_rvalid;
    endtask

    task automatic t_reset;
        chk_eq("R1 rvalid", {31'd0, io_rvalid}, 0);
        chk_eq("R1 err", {31'd0, io_err}, 0);
        chk_eq("R1 sticky", {31'd0, absent_wr_err}, 0);
        acc(16'h0CF8, 2, 0, 0);
        chk_eq("R1 latch", r_data, 0);
    endtask

    task automatic t_addr_full;
        logic [31:0] v;
        v = mk(1, 0, 3, 0, 5) | 32'h4000_0003;
        acc(16'h0CF8, 2, 1, v);
        chk_eq("R2 no rvalid on write", {31'd0, r_valid}, 0);
        acc(16'h0CF8, 2, 0, 0);
        chk_eq("R2 readback", r_data, v);
        chk_eq("R5 rvalid", {31'd0, r_valid}, 1);
        chk_eq("R5 single pulse", {31'd0, r_after}, 0);
    endtask

    task automatic t_addr_partial;
        acc(16'h0CF8, 2, 1, 32'h8000_1814);
        acc(16'h0CFA, 0, 1, 32'h0007_0000);
        acc(16'h0CF8, 2, 0, 0);
        chk_eq("R4 byte lane 2", r_data, 32'h8007_1814);
        acc(16'h0CF9, 1, 1, 32'hFFAB_CDFF);
        acc(16'h0CF8, 2, 0, 0);
        chk_eq("R4 word lanes 1-2", r_data, 32'h80AB_CD14);
        acc(16'h0CFA, 1, 0, 0);
        chk_eq("R5 word read lanes", r_data, 32'h80AB_0000);
        acc(16'h0CFB, 0, 0, 0);
        chk_eq("R5 byte read lane 3", r_data, 32'h8000_0000);
    endtask

    task automatic t_illegal;
        acc(16'h0CF8, 2, 1, 32'h1234_5678);
        acc(16'h0CF9, 2, 1, 32'hFFFF_FFFF);
        chk_eq("R3 dword at offset 1 err", {31'd0, r_err}, 1);
        acc(16'h0CFB, 1, 0, 0);
        chk_eq("R3 word at offset 3 err", {31'd0, r_err}, 1);
        chk_eq("R3 illegal read data", r_data, 0);
        acc(16'h0CF8, 3, 1, 32'hFFFF_FFFF);
        chk_eq("R3 size 3 err", {31'd0, r_err}, 1);
        acc(16'h0CF8, 2, 0, 0);
        chk_eq("R3 latch unchanged", r_data, 32'h1234_5678);
        chk_eq("R3 legal no err", {31'd0, r_err}, 0);
        acc(16'h0CF8, 2, 1, mk(1, 0, 3, 0, 5));
        acc(16'h0CFD, 2, 0, 0);
        chk_eq("R3 data window illegal no req", {31'd0, c_req}, 0);
        chk_eq("R3 data window illegal err", {31'd0, r_err}, 1);
    endtask

    task automatic t_cfg_access;
        logic [31:0] be_data;
        acc(16'h0CF8, 2, 1, mk(1, 0, 3, 0, 5));
        acc(16'h0CFE, 1, 0, 0);
        be_data = {3'b101, 5'd3, 2'b00, 6'd5, 16'h5AC3};
        chk_eq("R6 read req", {31'd0, c_req}, 1);
        chk_eq("R6 read we", {31'd0, c_we}, 0);
        chk_eq("R6 dev", {27'd0, c_dev}, 3);
        chk_eq("R7 reg", {26'd0, c_reg}, 5);
        chk_eq("R7 be word hi", {28'd0, c_be}, 4'b1100);
        chk_eq("R6 read data", r_data, be_data & 32'hFFFF_0000);
        acc(16'h0CFF, 0, 0, 0);
        chk_eq("R7 be byte 3", {28'd0, c_be}, 4'b1000);
        acc(16'h0CFC, 2, 1, 32'h1122_3344);
        chk_eq("R6 write req", {30'd0, c_req, c_we}, 2'b11);
        chk_eq("R6 write data", c_wdata, 32'h1122_3344);
        chk_eq("R7 be dword", {28'd0, c_be}, 4'b1111);
        chk_eq("R11 no sticky on present", {31'd0, absent_wr_err}, 0);
    endtask

    task automatic t_bus_nonzero;
        acc(16'h0CF8, 2, 1, mk(1, 2, 3, 0, 5));
        acc(16'h0CFC, 2, 0, 0);
        chk_eq("R8 all ones", r_data, 32'hFFFF_FFFF);
        chk_eq("R8 no req", {31'd0, c_req}, 0);
        acc(16'h0CFC, 2, 1, 32'hDEAD_BEEF);
        chk_eq("R10 no req", {31'd0, c_req}, 0);
        chk_eq("R10 no sticky", {31'd0, absent_wr_err}, 0);
    endtask

    task automatic t_absent;
        acc(16'h0CF8, 2, 1, mk(1, 0, 4, 0, 1));
        acc(16'h0CFD, 0, 0, 0);
        chk_eq("R9 byte ones", r_data, 32'h0000_FF00);
        chk_eq("R9 no req", {31'd0, c_req}, 0);
        acc(16'h0CFC, 2, 1, 32'h0BAD_F00D);
        chk_eq("R11 no req", {31'd0, c_req}, 0);
        chk_eq("R11 sticky set", {31'd0, absent_wr_err}, 1);
        repeat (3) @(negedge clk);
        chk_eq("R11 sticky held", {31'd0, absent_wr_err}, 1);
        err_clr = 1;
        @(negedge clk);
        err_clr = 0;
        chk_eq("R11 sticky cleared", {31'd0, absent_wr_err}, 0);
    endtask

    task automatic t_outside;
        acc(16'h0CF8, 2, 1, 32'h0000_0A0C);
        acc(16'h0CF0, 2, 0, 0);
        chk_eq("R12 no rvalid", {31'd0, r_valid}, 0);
        chk_eq("R12 no err", {31'd0, r_err}, 0);
        acc(16'h0D00, 2, 1, 32'hFFFF_FFFF);
        chk_eq("R12 no req", {31'd0, c_req}, 0);
        acc(16'h0CF8, 2, 0, 0);
        chk_eq("R12 latch unchanged", r_data, 32'h0000_0A0C);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_addr_full();
        t_addr_partial();
        t_illegal();
        t_cfg_access();
        t_bus_nonzero();
        t_absent();
        t_outside();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule